// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time as six packed-BCD bytes: seconds, minutes, hours, day of month, month and a two-digit year covering 2000 to 2099. A prescaler counts pulses of a 32.768 kHz clock enable. Each time it completes a second, the calendar advances by one second, and carries propagate up through the fields. The day field follows the length of the current month. February has 29 days whenever the year value is divisible by four.

Software uses a simple byte-wide register bus. Writes take effect on the clock edge and reads are combinational from the address. The time fields are at byte addresses 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14, in the order seconds, minutes, hours, day, month, year. The alarm fields use the same order at 0x20 through 0x34. The control register is at 0x40, the status register at 0x44 and the interrupt-enable register at 0x48. The alarm compares all six fields, and no field can be excluded from the comparison. A busy flag warns software in the last prescaler period before each update, so that time accesses can be placed in the quiet window that follows it.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, the time is 00 seconds, 00 minutes, 00 hours, day 0x01, month 0x01, year 0x00. The alarm fields, control, interrupt-enable and status registers all read 0x00, and both interrupt outputs are low.
- R2: When the calendar advances, seconds wrap from 0x59 to 0x00 and carry into minutes. Minutes wrap from 0x59 to 0x00 and carry into hours. Hours wrap from 0x23 to 0x00 and carry into the day.
- R3: The day wraps to 0x01 after its last day and carries into the month. The last day is 0x30 for months 0x04, 0x06, 0x09 and 0x11, and 0x31 for the other months except February. February ends on 0x29 when the year is divisible by four and on 0x28 otherwise. Month 0x12 wraps to 0x01 and carries into the year, and year 0x99 wraps to 0x00.
- R4: The calendar advances on the PRESCALE-th accepted tick of a second. Status bit 0 (busy) is 1 exactly during the final prescaler period before that update, while running, and 0 at all other times.
- R5: When an update produces a time in which all six fields equal the alarm registers, status bit 6 sets. A mismatch in any single field, including the year, prevents it from setting. Writing 1 to status bit 6 clears it.
- R6: Status bit 2 sets on every one-second update, and writing 1 to it clears it. irq_timer_o equals status bit 2 AND interrupt-enable bit 2. irq_alarm_o equals status bit 6 AND interrupt-enable bit 3.
- R7: Control bit 0 runs the clock, and status bit 1 reads 1 while it is set. With control bit 0 clear, or with tick_i low, the time does not change except through bus writes.
- R8: A write to a time register updates that field on the same clock edge and restarts the current second from zero prescaler ticks.
- R9: Control bit 3, which would select a 12-hour format, always reads 0 and writing it has no effect. Hours are always counted in 24-hour form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 32.768 kHz clock enable, one cycle per period |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1 (with req_i) |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_timer_o | output | 1 | One-second interrupt |
| irq_alarm_o | output | 1 | Alarm interrupt |

## Verification
The table of start times is chosen so that each entry ends a carry chain at a different field. The entries cover a plain seconds step, a minute and an hour carry, month ends of 30 and 31 days, February in a common year, a year divisible by four and the year 2000, and the full roll from 99-12-31 23:59:59. A mistake in any one rollover limit or leap rule therefore shows up in a distinct entry. Directed tests check the busy window against the exact update cycle and the prescaler restart on a time write. They also compare a full alarm match with a match that differs only in the year. Further tests confirm that a stopped clock or an absent tick holds the time.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_FIELDS = 6;
  typedef logic [7:0] bcd_t;
  typedef logic [NUM_FIELDS-1:0][7:0] cal_t;

  localparam bcd_t ADDR_TIME  = 8'h00;
  localparam bcd_t ADDR_ALARM = 8'h20;
  localparam bcd_t ADDR_CTRL  = 8'h40;
  localparam bcd_t ADDR_STAT  = 8'h44;
  localparam bcd_t ADDR_IEN   = 8'h48;

  localparam int CTRL_RUN    = 0;
  localparam int STAT_BUSY   = 0;
  localparam int STAT_RUN    = 1;
  localparam int STAT_SEC    = 2;
  localparam int STAT_ALARM  = 6;
  localparam int IEN_TIMER   = 2;
  localparam int IEN_ALARM   = 3;

  function automatic bcd_t bcd_inc(bcd_t v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic bcd_t last_day(bcd_t mon, bcd_t yr);
    logic [7:0] yb;
    yb = 8'(yr[7:4]) * 8'd10 + 8'(yr[3:0]);
    case (mon)
      8'h02:                      return (yb[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic restart_i,
  output logic busy_o,
  output logic sec_pulse_o
);
  localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q;

  assign busy_o      = run_i && (cnt_q == LAST);
  assign sec_pulse_o = busy_o && tick_i && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i)          cnt_q <= '0;
    else if (run_i && tick_i)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  adv_i,
  input  logic [NUM_FIELDS-1:0] we_i,
  input  bcd_t                  wdata_i,
  output cal_t                  time_o,
  output cal_t                  next_o
);
  cal_t time_q;
  logic [NUM_FIELDS:0] carry;
  logic [NUM_FIELDS-1:0] at_end;
  cal_t lim, wrap_to;

  always_comb begin
    lim     = {8'h99, 8'h12, last_day(time_q[4], time_q[5]), 8'h23, 8'h59, 8'h59};
    wrap_to = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
  end

  assign carry[0] = 1'b1;
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    assign at_end[i]  = (time_q[i] == lim[i]);
    assign carry[i+1] = carry[i] && at_end[i];
    assign next_o[i]  = !carry[i] ? time_q[i] : (at_end[i] ? wrap_to[i] : bcd_inc(time_q[i]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      time_q[i] <= wrap_to[i];
      else if (we_i[i]) time_q[i] <= wdata_i;
      else if (adv_i)   time_q[i] <= next_o[i];
    end
  end

  assign time_o = time_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_FIELDS-1:0] we_i,
  input  bcd_t                  wdata_i,
  input  logic                  adv_i,
  input  cal_t                  next_i,
  output cal_t                  alarm_o,
  output logic                  hit_o
);
  cal_t alm_q;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_alm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      alm_q[i] <= '0;
      else if (we_i[i]) alm_q[i] <= wdata_i;
    end
  end

  assign hit_o   = adv_i && (next_i == alm_q);
  assign alarm_o = alm_q;
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_timer_o,
  output logic       irq_alarm_o
);
  logic wr;
  logic [NUM_FIELDS-1:0] time_we, alm_we;
  logic ctrl_we, stat_we, ien_we;
  logic run_q, ien_timer_q, ien_alarm_q, flag_sec_q, flag_alarm_q;
  logic busy, sec_pulse, hit;
  cal_t time_q, time_next, alm_q;

  assign wr      = req_i && we_i;
  assign ctrl_we = wr && (addr_i == ADDR_CTRL);
  assign stat_we = wr && (addr_i == ADDR_STAT);
  assign ien_we  = wr && (addr_i == ADDR_IEN);

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
    assign time_we[i] = wr && (addr_i == ADDR_TIME + 8'(4 * i));
    assign alm_we[i]  = wr && (addr_i == ADDR_ALARM + 8'(4 * i));
  end

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk_i, .rst_ni,
    .run_i       (run_q),
    .tick_i      (tick_i),
    .restart_i   (|time_we),
    .busy_o      (busy),
    .sec_pulse_o (sec_pulse)
  );

  rtc_calendar u_cal (
    .clk_i, .rst_ni,
    .adv_i   (sec_pulse),
    .we_i    (time_we),
    .wdata_i (wdata_i),
    .time_o  (time_q),
    .next_o  (time_next)
  );

  rtc_alarm u_alm (
    .clk_i, .rst_ni,
    .we_i    (alm_we),
    .wdata_i (wdata_i),
    .adv_i   (sec_pulse),
    .next_i  (time_next),
    .alarm_o (alm_q),
    .hit_o   (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q        <= 1'b0;
      ien_timer_q  <= 1'b0;
      ien_alarm_q  <= 1'b0;
      flag_sec_q   <= 1'b0;
      flag_alarm_q <= 1'b0;
    end else begin
      if (ctrl_we) run_q <= wdata_i[CTRL_RUN];
      if (ien_we) begin
        ien_timer_q <= wdata_i[IEN_TIMER];
        ien_alarm_q <= wdata_i[IEN_ALARM];
      end
      // set beats write-one-to-clear
      flag_sec_q   <= sec_pulse || (flag_sec_q && !(stat_we && wdata_i[STAT_SEC]));
      flag_alarm_q <= hit || (flag_alarm_q && !(stat_we && wdata_i[STAT_ALARM]));
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (addr_i == ADDR_TIME + 8'(4 * i))  rdata_o = time_q[i];
      if (addr_i == ADDR_ALARM + 8'(4 * i)) rdata_o = alm_q[i];
    end
    case (addr_i)
      ADDR_CTRL: rdata_o[CTRL_RUN] = run_q;
      ADDR_STAT: begin
        rdata_o[STAT_BUSY]  = busy;
        rdata_o[STAT_RUN]   = run_q;
        rdata_o[STAT_SEC]   = flag_sec_q;
        rdata_o[STAT_ALARM] = flag_alarm_q;
      end
      ADDR_IEN: begin
        rdata_o[IEN_TIMER] = ien_timer_q;
        rdata_o[IEN_ALARM] = ien_alarm_q;
      end
      default: ;
    endcase
  end

  assign irq_timer_o = flag_sec_q && ien_timer_q;
  assign irq_alarm_o = flag_alarm_q && ien_alarm_q;
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk
  import rtc_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic wr,
  input logic run,
  input logic busy,
  input logic sec_pulse,
  input logic alarm_flag,
  input cal_t time_q,
  input cal_t alm_q
);
  AST_SEC_CHANGE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_q[0] != $past(time_q[0])) && !$past(wr) |-> $past(busy)); // R4

  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sec_pulse) && ($past(time_q[0]) == 8'h59) |-> (time_q[0] == 8'h00)); // R2

  AST_MONTH_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sec_pulse) && ($past(time_q[4]) >= 8'h01) && ($past(time_q[4]) <= 8'h12)
      |-> (time_q[4] >= 8'h01) && (time_q[4] <= 8'h12)); // R3

  AST_ALARM_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_flag) && !$past(wr) |-> (time_q == alm_q)); // R5

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run && !wr |=> $stable(time_q)); // R7
endmodule

bind rtc_bcd_core rtc_bcd_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr         (wr),
  .run        (run_q),
  .busy       (busy),
  .sec_pulse  (sec_pulse),
  .alarm_flag (flag_alarm_q),
  .time_q     (time_q),
  .alm_q      (alm_q)
);

// File: tb/rtc_bcd_core_bench.sv
module rtc_bcd_core_bench;
  localparam int PRE = 4;
  localparam int NV  = 12;
  // {start, expected after one second}, bytes yr mon day hr min sec
  localparam logic [95:0] VEC [NV] = '{
    {48'h00_01_01_00_00_00, 48'h00_01_01_00_00_01},
    {48'h99_12_31_23_59_59, 48'h00_01_01_00_00_00},
    {48'h23_02_28_23_59_59, 48'h23_03_01_00_00_00},
    {48'h24_02_28_23_59_59, 48'h24_02_29_00_00_00},
    {48'h00_02_29_23_59_59, 48'h00_03_01_00_00_00},
    {48'h15_04_30_23_59_59, 48'h15_05_01_00_00_00},
    {48'h15_01_30_23_59_59, 48'h15_01_31_00_00_00},
    {48'h50_06_15_12_59_09, 48'h50_06_15_12_59_10},
    {48'h10_10_10_23_09_59, 48'h10_10_10_23_10_00},
    {48'h10_10_10_09_59_59, 48'h10_10_10_10_00_00},
    {48'h31_08_31_23_59_59, 48'h31_09_01_00_00_00},
    {48'h96_02_29_23_59_59, 48'h96_03_01_00_00_00}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic irq_timer, irq_alarm;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rtc_bcd_core #(.PRESCALE(PRE)) u_rtc_bcd_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_timer_o(irq_timer), .irq_alarm_o(irq_alarm)
  );

  task automatic check(input string req_tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_time(input logic [47:0] t);
    for (int i = 0; i < 6; i++) wr(8'(4 * i), t[8*i +: 8]);
  endtask

  task automatic set_alarm(input logic [47:0] t);
    for (int i = 0; i < 6; i++) wr(8'h20 + 8'(4 * i), t[8*i +: 8]);
  endtask

  task automatic get_time(output logic [47:0] t);
    logic [7:0] b;
    for (int i = 0; i < 6; i++) begin
      rd(8'(4 * i), b);
      t[8*i +: 8] = b;
    end
  endtask

  task automatic one_second;
    wr(8'h40, 8'h01);
    repeat (PRE) @(posedge clk);
    wr(8'h40, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] t;
    logic [7:0] b;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset state
    get_time(t);
    check("R1 time", t, 48'h00_01_01_00_00_00);
    rd(8'h20, b); check("R1 alarm", {40'd0, b}, 48'h0);
    rd(8'h40, b); check("R1 ctrl", {40'd0, b}, 48'h0);
    rd(8'h44, b); check("R1 status", {40'd0, b}, 48'h0);
    rd(8'h48, b); check("R1 ien", {40'd0, b}, 48'h0);
    check("R1 irqs", {46'd0, irq_timer, irq_alarm}, 48'h0);

    // R2 R3 rollover table
    for (int v = 0; v < NV; v++) begin
      set_time(VEC[v][95:48]);
      one_second();
      get_time(t);
      check($sformatf("R2 R3 vector %0d", v), t, VEC[v][47:0]);
    end

    // R4 busy window, R6 second flag, R7 running status
    wr(8'h44, 8'h44);
    set_time(48'h00_01_01_00_00_00);
    wr(8'h40, 8'h01);
    rd(8'h44, b); check("R4 busy low early", {40'd0, b}, 48'h02);
    rd(8'h44, b);
    rd(8'h44, b); check("R4 busy high last period", {40'd0, b}, 48'h03);
    rd(8'h00, b); check("R4 update after busy", {40'd0, b}, 48'h01);
    rd(8'h44, b); check("R6 R7 status after second", {40'd0, b}, 48'h06);
    wr(8'h40, 8'h00);

    // R6 timer interrupt and write-one-to-clear
    wr(8'h48, 8'h04);
    check("R6 irq_timer set", {47'd0, irq_timer}, 48'h1);
    wr(8'h44, 8'h04);
    check("R6 irq_timer cleared", {47'd0, irq_timer}, 48'h0);
    rd(8'h44, b); check("R6 flag cleared", {40'd0, b}, 48'h00);

    // R8 time write is immediate and restarts the second
    set_time(48'h00_01_01_00_00_00);
    wr(8'h40, 8'h01);
    wr(8'h00, 8'h10);
    rd(8'h00, b);
    rd(8'h00, b); check("R8 no early update", {40'd0, b}, 48'h10);
    rd(8'h00, b);
    rd(8'h00, b); check("R8 full second after write", {40'd0, b}, 48'h11);
    wr(8'h40, 8'h00);

    // R7 hold when stopped or without tick
    set_time(48'h42_07_04_11_22_33);
    repeat (20) @(posedge clk);
    get_time(t); check("R7 stopped holds", t, 48'h42_07_04_11_22_33);
    wr(8'h40, 8'h01);
    tick = 1'b0;
    repeat (20) @(posedge clk);
    wr(8'h40, 8'h00);
    tick = 1'b1;
    get_time(t); check("R7 no tick holds", t, 48'h42_07_04_11_22_33);

    // R9 12-hour select ignored
    wr(8'h40, 8'h08);
    rd(8'h40, b); check("R9 ctrl bit3", {40'd0, b}, 48'h00);
    wr(8'h40, 8'h00);

    // R5 alarm full match
    wr(8'h48, 8'h08);
    wr(8'h44, 8'h44);
    set_alarm(48'h00_01_01_00_00_00);
    set_time(48'h99_12_31_23_59_59);
    one_second();
    rd(8'h44, b); check("R5 alarm flag", {47'd0, b[6]}, 48'h1);
    check("R6 irq_alarm", {46'd0, irq_timer, irq_alarm}, 48'h1);
    wr(8'h44, 8'h40);
    rd(8'h44, b); check("R5 alarm clear", {47'd0, b[6]}, 48'h0);
    check("R6 irq_alarm low", {47'd0, irq_alarm}, 48'h0);

    // R5 year mismatch only
    set_alarm(48'h01_01_01_00_00_00);
    set_time(48'h99_12_31_23_59_59);
    one_second();
    rd(8'h44, b); check("R5 year mismatch no alarm", {47'd0, b[6]}, 48'h0);
    check("R5 irq_alarm stays low", {47'd0, irq_alarm}, 48'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule